// File: doc/BRIEF.md
# Rotate and Mask Unit

This block is the rotate-and-mask datapath of a 64-bit integer execution pipe. It rotates a source word to the left by 0 to 63 positions, builds a contiguous mask that may wrap around, and then either clears every rotated bit outside the mask or merges the rotated bits into a previous destination value under the mask. A word mode works on the low 32 bits of the source. In this mode the amount and the mask fields lose their top bit, and the mask is moved into the low half of the word.

Bits are numbered big-endian. Position 0 is the most significant bit, `[63]` of a port vector, and position 63 is `[0]`. "Rotate left" moves bits toward position 0. The result is registered, so it appears one clock after the operands are applied. A three-bit condition field, also registered, is updated from the signed result only when the record input is high. Decode sets up the usual sub-cases by choosing the fields: clear-left uses end 63, clear-right uses begin 0, and a logical right shift by n uses amount 64-n with begin n. The block applies no fixed case of its own.

Top module: `rot_mask_unit`

## Requirements
- R1: With `word_i`=0, the value rotated is `rs_i`, rotated left by `amt_i` positions. A bit that leaves position 0 re-enters at position 63. An amount of 0 returns the source unchanged, and an amount of 63 equals a rotate right by one.
- R2: With `word_i`=1, the value rotated is two copies of `rs_i[31:0]` placed side by side. The amount is `amt_i[4:0]`, and `amt_i[5]` is ignored.
- R3: When begin <= end, the mask is ones from position begin through position end inclusive. A single-bit mask results when begin equals end. No field setting gives an all-zero mask.
- R4: When begin > end, the mask is ones in positions begin..63 and in positions 0..end.
- R5: With `word_i`=1, begin is `mb_i[4:0]`+32 and end is `me_i[4:0]`+32, and `mb_i[5]` and `me_i[5]` are ignored. When the 5-bit begin <= end in AND mode, `res_o[63:32]` is zero. A wrapping word mask sets ones in the upper half.
- R6: With `insert_i`=0, the result is the rotated value ANDed with the mask.
- R7: With `insert_i`=1, each result bit is the rotated bit where the mask is 1 and the `ra_i` bit where the mask is 0.
- R8: When `rec_i`=1, the next `cr_o` is {LT,GT,EQ}: `cr_o[2]`=result negative as a signed 64-bit value, `cr_o[1]`=result positive, and `cr_o[0]`=result zero. Exactly one of the three bits is set.
- R9: When `rec_i`=0, `cr_o` keeps its value on that clock.
- R10: `res_o` shows the result for the operands sampled on the previous rising edge. An active-low asynchronous reset clears `res_o` and `cr_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs_i | input | 64 | Source word |
| ra_i | input | 64 | Previous destination value, used in insert mode |
| amt_i | input | 6 | Left rotate amount |
| mb_i | input | 6 | Mask begin position |
| me_i | input | 6 | Mask end position |
| word_i | input | 1 | 1: 32-bit word mode, 0: 64-bit mode |
| insert_i | input | 1 | 1: insert under mask, 0: AND with mask |
| rec_i | input | 1 | Update the condition field |
| res_o | output | 64 | Registered result |
| cr_o | output | 3 | Condition field {LT,GT,EQ} |

## Verification
The hardest case to reach is a word-mode wrapping mask combined with unused upper field bits. A slip in the +32 offset or in the masking of bit 5 shows up only when begin > end in word mode, or when `mb_i[5]`, `me_i[5]` or `amt_i[5]` is set. Directed vectors set these bits on purpose, and an all-ones source makes every mask bit visible at the output. A seeded pseudo-random sweep then mixes modes, amounts and field orders, and compares each result with a per-bit reference that counts positions big-endian.

// File: rtl/rot_mask_pkg.sv
package rot_mask_pkg;
  localparam int unsigned XLEN = 64;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cond_t;
endpackage

// File: rtl/rot_mask_src.sv
// Operand shaping: doubleword passes through, word duplicates the low half
// and pins the mask into the low half by forcing the top field bit.
module rot_mask_src #(
  parameter  int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W),
  localparam int unsigned HW  = W / 2
) (
  input  logic [W-1:0]   rs_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [SHW-1:0] mb_i,
  input  logic [SHW-1:0] me_i,
  input  logic           word_i,
  output logic [W-1:0]   data_o,
  output logic [SHW-1:0] amt_o,
  output logic [SHW-1:0] beg_o,
  output logic [SHW-1:0] end_o
);
  assign data_o = word_i ? {2{rs_i[HW-1:0]}} : rs_i;
  assign amt_o  = word_i ? {1'b0, amt_i[SHW-2:0]} : amt_i;
  assign beg_o  = word_i ? {1'b1, mb_i[SHW-2:0]}  : mb_i;
  assign end_o  = word_i ? {1'b1, me_i[SHW-2:0]}  : me_i;
endmodule

// File: rtl/rot_mask_rotl.sv
// Log-depth left rotator, one stage per amount bit.
module rot_mask_rotl #(
  parameter  int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   data_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   data_o
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = data_i;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    assign stage[s+1] = amt_i[s] ? {stage[s][W-K-1:0], stage[s][W-1:W-K]}
                                 : stage[s];
  end

  assign data_o = stage[SHW];
endmodule

// File: rtl/rot_mask_gen.sv
// Mask generator, big-endian positions; position p maps to index W-1-p.
module rot_mask_gen #(
  parameter  int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [SHW-1:0] beg_i,
  input  logic [SHW-1:0] end_i,
  output logic [W-1:0]   mask_o
);
  logic [W-1:0] from_beg;
  logic [W-1:0] upto_end;

  assign from_beg = {W{1'b1}} >> beg_i;
  assign upto_end = ~(({W{1'b1}} >> end_i) >> 1);
  assign mask_o   = (beg_i <= end_i) ? (from_beg & upto_end)
                                     : (from_beg | upto_end);
endmodule

// File: rtl/rot_mask_merge.sv
module rot_mask_merge
  import rot_mask_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] rot_i,
  input  logic [W-1:0] ra_i,
  input  logic [W-1:0] mask_i,
  input  logic         insert_i,
  output logic [W-1:0] res_o,
  output cond_t        cond_o
);
  assign res_o = (rot_i & mask_i) | (insert_i ? (ra_i & ~mask_i) : '0);

  assign cond_o.lt = res_o[W-1];
  assign cond_o.eq = ~|res_o;
  assign cond_o.gt = ~res_o[W-1] & |res_o;
endmodule

// File: rtl/rot_mask_unit.sv
module rot_mask_unit
  import rot_mask_pkg::*;
#(
  parameter  int unsigned W   = XLEN,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   rs_i,
  input  logic [W-1:0]   ra_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [SHW-1:0] mb_i,
  input  logic [SHW-1:0] me_i,
  input  logic           word_i,
  input  logic           insert_i,
  input  logic           rec_i,
  output logic [W-1:0]   res_o,
  output logic [2:0]     cr_o
);
  logic [W-1:0]   src_data;
  logic [SHW-1:0] src_amt;
  logic [SHW-1:0] msk_beg;
  logic [SHW-1:0] msk_end;
  logic [W-1:0]   rot_data;
  logic [W-1:0]   mask;
  logic [W-1:0]   res_d;
  cond_t          cond_d;
  logic [W-1:0]   res_q;
  logic [2:0]     cr_q;

  rot_mask_src #(.W(W)) u_src (
    .rs_i   (rs_i),
    .amt_i  (amt_i),
    .mb_i   (mb_i),
    .me_i   (me_i),
    .word_i (word_i),
    .data_o (src_data),
    .amt_o  (src_amt),
    .beg_o  (msk_beg),
    .end_o  (msk_end)
  );

  rot_mask_rotl #(.W(W)) u_rotl (
    .data_i (src_data),
    .amt_i  (src_amt),
    .data_o (rot_data)
  );

  rot_mask_gen #(.W(W)) u_mask (
    .beg_i  (msk_beg),
    .end_i  (msk_end),
    .mask_o (mask)
  );

  rot_mask_merge #(.W(W)) u_merge (
    .rot_i    (rot_data),
    .ra_i     (ra_i),
    .mask_i   (mask),
    .insert_i (insert_i),
    .res_o    (res_d),
    .cond_o   (cond_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      cr_q  <= '0;
    end else begin
      res_q <= res_d;
      if (rec_i) cr_q <= cond_d;
    end
  end

  assign res_o = res_q;
  assign cr_o  = cr_q;
endmodule

// File: rtl/rot_mask_unit_chk.sv
module rot_mask_unit_chk #(
  parameter  int unsigned W   = 64,
  localparam int unsigned SHW = $clog2(W),
  localparam int unsigned HW  = W / 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [W-1:0]   ra_i,
  input logic [SHW-1:0] mb_i,
  input logic [SHW-1:0] me_i,
  input logic           word_i,
  input logic           insert_i,
  input logic           rec_i,
  input logic [W-1:0]   mask,
  input logic [W-1:0]   res_o,
  input logic [2:0]     cr_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  AST_MASK_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask != '0); // R3

  AST_AND_CLEARS_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(insert_i) |-> (res_o & ~$past(mask)) == '0); // R6

  AST_INSERT_KEEPS_RA: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(insert_i) |-> ((res_o ^ $past(ra_i)) & ~$past(mask)) == '0); // R7

  AST_WORD_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(word_i && !insert_i && (mb_i[SHW-2:0] <= me_i[SHW-2:0]))
      |-> res_o[W-1:HW] == '0); // R5

  AST_COND_ONEHOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cr_o)); // R8

  AST_COND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$past(rec_i) |-> $stable(cr_o)); // R9
endmodule

bind rot_mask_unit rot_mask_unit_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ra_i     (ra_i),
  .mb_i     (mb_i),
  .me_i     (me_i),
  .word_i   (word_i),
  .insert_i (insert_i),
  .rec_i    (rec_i),
  .mask     (mask),
  .res_o    (res_o),
  .cr_o     (cr_o)
);

// File: tb/rot_mask_unit_bench.sv
module rot_mask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct {
    logic [63:0] res;
    logic [2:0]  cr;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] rs_i = '0;
  logic [63:0] ra_i = '0;
  logic [5:0]  amt_i = '0;
  logic [5:0]  mb_i = '0;
  logic [5:0]  me_i = '0;
  logic        word_i = 1'b0;
  logic        insert_i = 1'b0;
  logic        rec_i = 1'b0;
  logic [63:0] res_o;
  logic [2:0]  cr_o;

  item_t       exp_q[$];
  logic [2:0]  exp_cr = 3'b000;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rot_mask_unit u_rot_mask_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rs_i     (rs_i),
    .ra_i     (ra_i),
    .amt_i    (amt_i),
    .mb_i     (mb_i),
    .me_i     (me_i),
    .word_i   (word_i),
    .insert_i (insert_i),
    .rec_i    (rec_i),
    .res_o    (res_o),
    .cr_o     (cr_o)
  );

  // Per-bit reference, positions counted big-endian (position p is bit [63-p]).
  function automatic logic [63:0] ref_res(input logic [63:0] rs, input logic [63:0] ra,
                                          input int amt, input int mb, input int me,
                                          input bit word, input bit ins);
    logic [63:0] src;
    logic [63:0] r;
    int n, b, e;
    src = word ? {rs[31:0], rs[31:0]} : rs;
    n   = word ? amt % 32 : amt;
    b   = word ? (mb % 32) + 32 : mb;
    e   = word ? (me % 32) + 32 : me;
    for (int p = 0; p < 64; p++) begin
      bit m;
      m = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
      if (m)        r[63-p] = src[63 - ((p + n) % 64)];
      else if (ins) r[63-p] = ra[63-p];
      else          r[63-p] = 1'b0;
    end
    return r;
  endfunction

  function automatic logic [2:0] ref_cr(input logic [63:0] r);
    if (r == 64'd0)   return 3'b001;
    else if (r[63])   return 3'b100;
    else              return 3'b010;
  endfunction

  task automatic push(input logic [63:0] r, input bit rec, input string tag);
    item_t it;
    if (rec) exp_cr = ref_cr(r);
    it.res = r;
    it.cr  = exp_cr;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic drive(input logic [63:0] rs, input logic [63:0] ra, input int amt,
                       input int mb, input int me, input bit word, input bit ins,
                       input bit rec);
    @(negedge clk_i);
    rs_i = rs; ra_i = ra; amt_i = 6'(amt); mb_i = 6'(mb); me_i = 6'(me);
    word_i = word; insert_i = ins; rec_i = rec;
  endtask

  task automatic apply(input logic [63:0] rs, input logic [63:0] ra, input int amt,
                       input int mb, input int me, input bit word, input bit ins,
                       input bit rec, input string tag);
    drive(rs, ra, amt, mb, me, word, ins, rec);
    push(ref_res(rs, ra, amt, mb, me, word, ins), rec, tag);
  endtask

  task automatic apply_fix(input logic [63:0] rs, input logic [63:0] ra, input int amt,
                           input int mb, input int me, input bit word, input bit ins,
                           input bit rec, input logic [63:0] expv, input string tag);
    drive(rs, ra, amt, mb, me, word, ins, rec);
    push(expv, rec, tag);
  endtask

  // Monitor: the result registers on the edge after the drive, sample 1 unit later.
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() != 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (res_o !== it.res) begin
          fails++;
          $display("FAIL %s res: got %h exp %h", it.tag, res_o, it.res);
        end
        checks++;
        if (cr_o !== it.cr) begin
          fails++;
          $display("FAIL %s cr: got %b exp %b", it.tag, cr_o, it.cr);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (res_o !== 64'd0 || cr_o !== 3'b000) begin
      fails++;
      $display("FAIL R10 reset: got %h/%b exp 0/000", res_o, cr_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    apply_fix(64'h8000_0000_0000_0001, 0, 1, 0, 63, 0, 0, 0, 64'h3, "R1 wrap out of pos0");
    apply_fix(64'h0123_4567_89AB_CDEF, 0, 0, 0, 63, 0, 0, 0, 64'h0123_4567_89AB_CDEF, "R1 amount 0");
    apply_fix(64'h8000_0000_0000_0000, 0, 63, 0, 63, 0, 0, 0, 64'h4000_0000_0000_0000, "R1 amount 63");
    apply_fix(64'hFFFF_0000_8000_0001, 0, 33, 0, 31, 1, 0, 0, 64'h3, "R2 word rotate, amt bit5 ignored");
    apply_fix('1, 0, 0, 10, 10, 0, 0, 0, 64'h0020_0000_0000_0000, "R3 begin equals end");
    apply_fix('1, 0, 0, 60, 3, 0, 0, 0, 64'hF000_0000_0000_000F, "R4 wrap mask");
    apply_fix('1, 0, 32, 30, 1, 1, 0, 0, 64'hFFFF_FFFF_C000_0003, "R5 R4 word wrap mask");
    apply_fix('1, 0, 32, 32, 31, 1, 0, 0, 64'h0000_0000_FFFF_FFFF, "R5 word mask, field bit5 ignored");
    apply_fix(64'hF000_0000_0000_0000, 0, 60, 4, 63, 0, 0, 0, 64'h0F00_0000_0000_0000, "R6 shift right by 4");
    apply_fix('1, 64'h1111_1111_1111_1111, 0, 8, 15, 0, 1, 0, 64'h11FF_1111_1111_1111, "R7 doubleword insert");
    apply_fix(64'h0000_0000_0000_00FF, 64'hAAAA_AAAA_AAAA_AAAA, 8, 16, 23, 1, 1, 0,
              64'hAAAA_AAAA_AAAA_FFAA, "R7 word insert");
    apply_fix('1, 0, 0, 0, 63, 0, 0, 1, '1, "R8 negative");
    apply_fix(64'd0, 0, 5, 0, 63, 0, 0, 1, 64'd0, "R8 zero");
    apply_fix(64'h3, 0, 0, 0, 63, 0, 0, 1, 64'h3, "R8 positive");
    apply_fix('1, 0, 0, 0, 63, 0, 0, 0, '1, "R9 record off holds");
    apply_fix(64'd0, 0, 0, 0, 63, 0, 0, 0, 64'd0, "R9 record off, zero result");

    for (int i = 0; i < 80; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 7);
      lfsr = lfsr ^ (lfsr << 17);
      apply({lfsr[31:0], lfsr[63:32]} ^ 64'h5A5A_0F0F_C3C3_9696, lfsr,
            int'(lfsr[5:0]), int'(lfsr[11:6]), int'(lfsr[17:12]),
            lfsr[20], lfsr[21], lfsr[22], "R1 R2 R6 R7 R8 R10 sweep");
    end

    repeat (3) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule